// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block gathers level-sensitive interrupt requests from a row of device slots, each slot carrying four request pins, and folds them onto four shared interrupt lines. Every pin is steered to one line by a rotation that depends on the slot number, so pin 0 of neighbouring slots lands on different lines and the load spreads across the four outputs.

For each line the block keeps a reference count: the number of device pins that currently hold that line asserted. The count moves only when a pin level actually changes, up by one on a rising level and down by one on a falling level, and the line is high whenever its count is non-zero. The four counts are exposed on a read port. A load strobe writes them back, so that the interrupt state can be captured and later reinstated.

Top module: `irq_line_aggregator`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, all counts read zero and all lines are low. Reset also clears the remembered pin levels, so a pin that is already high when reset ends is counted as a rising level on the first clock edge after release.
- R2: Pin `p` of slot `s` is carried on bit `s*4+p` of `pin_lvl`. It is routed to line `(p + s) mod 4`. The count of line `l` is read on `cnt_out[l*CNT_W +: CNT_W]`.
- R3: A pin that goes from 0 to 1 raises the count of its routed line by exactly one. The new count is visible after the same clock edge that samples the new level.
- R4: A pin that goes from 1 to 0 lowers the count of its routed line by exactly one, on the same clock edge that samples the new level.
- R5: Sampling a pin at the level it held on the previous edge leaves every count unchanged.
- R6: Line `l` of `line_out` is high exactly when the count of line `l` is non-zero.
- R7: When several pins change on the same edge, every one of their increments and decrements is applied on that edge. A rise and a fall routed to the same line cancel out.
- R8: Each count is wide enough to hold `4*NUM_SLOTS`. With every pin of every slot high, each line holds a count of `NUM_SLOTS`.
- R9: While `restore_en` is high on an edge, the counts are loaded from `restore_cnt`, using the same field layout as `cnt_out`. Pin changes sampled on that edge are not counted, and the pin levels sampled on that edge become the remembered levels. Loaded values must lie between 0 and `4*NUM_SLOTS`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | NUM_SLOTS*4 | Request pin levels, slot-major, four pins per slot |
| restore_en | input | 1 | Load the counts from `restore_cnt` on this edge |
| restore_cnt | input | 4*CNT_W | Count values to load, one field per line |
| line_out | output | 4 | Shared interrupt line levels |
| cnt_out | output | 4*CNT_W | Current reference count of each line |

## Verification
A count that drifts, whether from a lost increment, a doubled decrement or a change routed to the wrong line, appears on `cnt_out` after the very edge that sampled the offending pin change. It then stays wrong on every later cycle, because counts only ever move by differences. The line output shows the same fault only when the corrupted count crosses zero: a line can be stuck high long after every pin has dropped, or drop early while pins still request it. The bench therefore compares the full count vector against a reference model every cycle rather than watching the lines alone. It also drives the counts back to zero at the end of sequences to expose any residue.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   localparam int LINES = 4;

   // bits needed to hold 0 .. 4*slots
   function automatic int cnt_width(input int slots);
      return $clog2(LINES * slots + 1);
   endfunction

   // slot-based rotation of a pin onto a shared line
   function automatic int route_line(input int slot, input int pin);
      return (pin + slot) % LINES;
   endfunction

endpackage

// File: rtl/irq_lvl_tracker.sv
module irq_lvl_tracker
   import irq_agg_pkg::*;
#(
   parameter int SLOTS = 8,
   localparam int W = SLOTS * LINES
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin_lvl,
   input  logic         snap,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);

   logic [W-1:0] lvl_q;

   // remembered level always follows the sampled input; snap only hides edges
   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= pin_lvl;
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam int LO = s * LINES;
      assign rise[LO +: LINES] = pin_lvl[LO +: LINES] & ~lvl_q[LO +: LINES] & {LINES{~snap}};
      assign fall[LO +: LINES] = ~pin_lvl[LO +: LINES] & lvl_q[LO +: LINES] & {LINES{~snap}};
   end

   // R5
   repeat_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && pin_lvl == $past(pin_lvl)) |-> (rise == '0 && fall == '0));

endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
   import irq_agg_pkg::*;
#(
   parameter int SLOTS = 8,
   localparam int W   = SLOTS * LINES,
   localparam int UPW = $clog2(SLOTS + 1)
) (
   input  logic [W-1:0]                rise,
   input  logic [W-1:0]                fall,
   output logic [LINES-1:0][UPW-1:0]   up,
   output logic [LINES-1:0][UPW-1:0]   dn
);

   always_comb begin
      up = '0;
      dn = '0;
      for (int s = 0; s < SLOTS; s++) begin
         for (int p = 0; p < LINES; p++) begin
            for (int l = 0; l < LINES; l++) begin
               if (route_line(s, p) == l) begin
                  up[l] = up[l] + UPW'(rise[s*LINES+p]);
                  dn[l] = dn[l] + UPW'(fall[s*LINES+p]);
               end
            end
         end
      end
   end

endmodule

// File: rtl/irq_ref_counter.sv
module irq_ref_counter #(
   parameter int CW   = 6,
   parameter int UPW  = 4,
   parameter int MAXV = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ld,
   input  logic [CW-1:0]  ld_val,
   input  logic [UPW-1:0] up,
   input  logic [UPW-1:0] dn,
   output logic [CW-1:0]  cnt,
   output logic           active
);

   if (UPW > CW) begin : g_bad_width
      $error("irq_ref_counter: step width exceeds count width");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_d;

   always_comb begin
      if (ld) cnt_d = ld_val;
      else    cnt_d = cnt_q + CW'(up) - CW'(dn);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cnt    = cnt_q;
   assign active = |cnt_q;

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(MAXV));

   // R9
   restore_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (cnt_q == $past(ld_val)));

   // R7
   balance_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && up == dn) |=> $stable(cnt_q));

   // R3
   count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && up > dn) |=> (cnt_q > $past(cnt_q)));

   // R4
   count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && dn > up) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/irq_line_aggregator.sv
module irq_line_aggregator
   import irq_agg_pkg::*;
#(
   parameter int  NUM_SLOTS = 8,
   localparam int CNT_W = cnt_width(NUM_SLOTS),
   localparam int PIN_W = NUM_SLOTS * LINES
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [PIN_W-1:0]       pin_lvl,
   input  logic                   restore_en,
   input  logic [LINES*CNT_W-1:0] restore_cnt,
   output logic [LINES-1:0]       line_out,
   output logic [LINES*CNT_W-1:0] cnt_out
);

   localparam int UPW  = $clog2(NUM_SLOTS + 1);
   localparam int MAXV = LINES * NUM_SLOTS;

   if (NUM_SLOTS < 1) begin : g_bad_slots
      $error("irq_line_aggregator: NUM_SLOTS must be at least 1");
   end

   logic [PIN_W-1:0]            rise;
   logic [PIN_W-1:0]            fall;
   logic [LINES-1:0][UPW-1:0]   up;
   logic [LINES-1:0][UPW-1:0]   dn;

   irq_lvl_tracker #(.SLOTS(NUM_SLOTS)) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_lvl (pin_lvl),
      .snap    (restore_en),
      .rise    (rise),
      .fall    (fall)
   );

   irq_line_router #(.SLOTS(NUM_SLOTS)) u_route (
      .rise (rise),
      .fall (fall),
      .up   (up),
      .dn   (dn)
   );

   for (genvar l = 0; l < LINES; l++) begin : g_line
      irq_ref_counter #(.CW(CNT_W), .UPW(UPW), .MAXV(MAXV)) u_cnt (
         .clk    (clk),
         .rst_n  (rst_n),
         .ld     (restore_en),
         .ld_val (restore_cnt[l*CNT_W +: CNT_W]),
         .up     (up[l]),
         .dn     (dn[l]),
         .cnt    (cnt_out[l*CNT_W +: CNT_W]),
         .active (line_out[l])
      );
   end

   // R5
   quiet_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !restore_en && pin_lvl == $past(pin_lvl)) |=> $stable(cnt_out));

   // R6
   line_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_out[0]) |-> (cnt_out[0 +: CNT_W] != '0));

endmodule

// File: tb/irq_line_aggregator_test.sv
module irq_line_aggregator_test;

   localparam int N  = 8;
   localparam int CW = $clog2(4 * N + 1);
   localparam int W  = N * 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [W-1:0]    pin_lvl = '0;
   logic            restore_en = 1'b0;
   logic [4*CW-1:0] restore_cnt = '0;
   logic [3:0]      line_out;
   logic [4*CW-1:0] cnt_out;

   always #5 clk = ~clk;

   irq_line_aggregator #(.NUM_SLOTS(N)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_lvl     (pin_lvl),
      .restore_en  (restore_en),
      .restore_cnt (restore_cnt),
      .line_out    (line_out),
      .cnt_out     (cnt_out)
   );

   typedef struct {
      logic [4*CW-1:0] cnt;
      logic [3:0]      lines;
      string           tag;
   } exp_t;

   exp_t         q[$];
   int           n_run = 0;
   int           n_fail = 0;
   logic [W-1:0] m_lvl = '0;
   int           m_cnt[4] = '{0, 0, 0, 0};
   logic [31:0]  lf = 32'h1ACE_2B07;

   function automatic int pin_bit(input int s, input int p);
      return s * 4 + p;
   endfunction

   function automatic logic [4*CW-1:0] pack4(input int a, input int b, input int c, input int d);
      return {CW'(d), CW'(c), CW'(b), CW'(a)};
   endfunction

   // driver: apply one cycle of stimulus and push the expected result
   task automatic step(input logic [W-1:0] pins, input logic ld,
                       input logic [4*CW-1:0] ldv, input string tag);
      exp_t e;
      @(negedge clk);
      pin_lvl     = pins;
      restore_en  = ld;
      restore_cnt = ldv;
      for (int s = 0; s < N; s++)
         for (int p = 0; p < 4; p++)
            if (!ld && pins[pin_bit(s, p)] != m_lvl[pin_bit(s, p)])
               m_cnt[(p + s) % 4] += pins[pin_bit(s, p)] ? 1 : -1;
      if (ld)
         for (int l = 0; l < 4; l++) m_cnt[l] = int'(ldv[l*CW +: CW]);
      m_lvl = pins;
      for (int l = 0; l < 4; l++) begin
         e.cnt[l*CW +: CW] = CW'(m_cnt[l]);
         e.lines[l]        = (m_cnt[l] != 0);
      end
      e.tag = tag;
      q.push_back(e);
   endtask

   // monitor: compare one expected item shortly after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (cnt_out !== e.cnt || line_out !== e.lines) begin
               n_fail++;
               $display("FAIL %s: actual cnt=%h lines=%b expected cnt=%h lines=%b",
                        e.tag, cnt_out, line_out, e.cnt, e.lines);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [W-1:0] pins;
      repeat (3) @(posedge clk);
      #2;
      n_run++;
      if (cnt_out !== '0 || line_out !== 4'b0) begin
         n_fail++;
         $display("FAIL R1 in reset: actual cnt=%h lines=%b expected cnt=0 lines=0",
                  cnt_out, line_out);
      end
      @(negedge clk);
      rst_n = 1'b1;
      step('0, 1'b0, '0, "R1 after release");

      pins = '0;
      pins[pin_bit(0, 0)] = 1'b1;
      step(pins, 1'b0, '0, "R3 slot0 pin0 rise to line0");
      pins[pin_bit(1, 0)] = 1'b1;
      step(pins, 1'b0, '0, "R2 slot1 pin0 onto line1");
      pins[pin_bit(3, 2)] = 1'b1;
      step(pins, 1'b0, '0, "R2 slot3 pin2 onto line1");
      step(pins, 1'b0, '0, "R5 repeated level");
      step(pins, 1'b0, '0, "R5 repeated level again");
      pins[pin_bit(0, 0)] = 1'b0;
      step(pins, 1'b0, '0, "R4 slot0 pin0 fall, R6 line0 low");
      pins[pin_bit(1, 0)] = 1'b0;
      pins[pin_bit(5, 0)] = 1'b1;
      pins[pin_bit(2, 3)] = 1'b1;
      step(pins, 1'b0, '0, "R7 rise and fall on line1 together");
      step('0, 1'b0, '0, "R7 three falls at once, R6 all low");

      for (int i = 0; i < 40; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         step(lf[W-1:0], 1'b0, '0, "R7 mixed pattern");
      end
      step('1, 1'b0, '0, "R8 every pin high");
      step('1, 1'b0, '0, "R5 every pin held");
      step('0, 1'b0, '0, "R4 every pin low");

      // restore with a pin change on the load edge
      pins = '0;
      pins[pin_bit(0, 1)] = 1'b1;
      step(pins, 1'b1, pack4(3, 5, 0, 7), "R9 counts loaded, edge ignored");
      step(pins, 1'b0, '0, "R9 loaded counts held");
      step('0, 1'b0, '0, "R9 fall after load decrements line1");
      step('0, 1'b1, pack4(0, 0, 0, 0), "R9 load zero");
      step('1, 1'b1, pack4(8, 8, 8, 8), "R9 load with all pins high");
      step('0, 1'b0, '0, "R6 all falls after load reach zero");

      // reset with a pin high: counted as a rise after release
      @(negedge clk);
      rst_n = 1'b0;
      pin_lvl = '0;
      pin_lvl[pin_bit(2, 1)] = 1'b1;
      m_lvl = '0;
      foreach (m_cnt[l]) m_cnt[l] = 0;
      @(negedge clk);
      rst_n = 1'b1;
      pins = '0;
      pins[pin_bit(2, 1)] = 1'b1;
      step(pins, 1'b0, '0, "R1 high pin at release counts on line3");

      repeat (4) @(posedge clk);
      #3;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule